// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Alternate-Function Override

This block controls one 8-bit general-purpose I/O port. Each pin has a direction bit and a data bit. An output pin drives its data bit push-pull. On an input pin the data bit turns the pull-up on or off. Software reaches the two registers and a read-only view of the pin levels through a small register bus. The block drives three signals per pin to the pad models: output-enable, output-value and pull-up-enable. The pin levels come back already synchronized.

Alternate functions take a pin away from its register settings one pin at a time:
- **UART pins.** Two UART channels can be mapped onto the low four pins. A mapped transmitter owns its pin as an output. A mapped and enabled receiver forces its pin to be an input, while the data bit still controls the pull-up.
- **Interrupt pins.** The four upper pins can raise active-low external interrupt requests while their level is low.
- **Check pin.** When the check-pin function is enabled, a low configuration-download strobe floats the top pin at once. That pin can still be read and can still raise its interrupt.

While reset is low, every pin is an input with its pull-up on. This forcing is combinational, so it does not wait for a clock edge.

Top module: `gpio_alt_port`

## Requirements
- R1: When a pin's direction bit is 1 and no alternate function claims it, its pad_oe is 1, its pad_out equals its data bit and its pad_pu is 0.
- R2: When a pin's direction bit is 0 and no alternate function claims it, its pad_oe is 0 and its pad_pu equals its data bit. pad_out is 0 whenever pad_oe is 0, and pad_oe and pad_pu are never both 1.
- R3: While rst_n is 0, pad_oe is 8'h00 and pad_pu is 8'hFF, with no clock edge needed. A clock edge with rst_n low loads the data register with 8'hFF and the direction register with 8'h00.
- R4: The bus writes on bus_wr at a clock edge, and reads combinationally through bus_rdata. Offset 0 is the data register and offset 1 is the direction register; both can be read and written. Offset 2 returns pin_in, and writes to it change nothing. Offset 3 reads 0.
- R5: When uart0_map is 1, pin 0 has pad_oe 1, pad_out equal to uart0_txd and pad_pu 0, whatever its register bits. uart1_map does the same for pin 2 with uart1_txd.
- R6: When uart0_map and uart0_rx_en are both 1, pin 1 has pad_oe 0 even if its direction bit is 1, and pad_pu equals data bit 1. The uart1 signals do the same for pin 3. uart0_rxd equals pin_in[1] while uart0_map is 1 and is 1 otherwise. uart1_rxd behaves the same with pin_in[3].
- R7: irq_n[k] is 0 exactly when int_en[k] is 1 and pin_in[4+k] is 0, for k = 0 to 3. Nothing is latched: the request clears as soon as the pin returns high.
- R8: When chk_en is 1 and cfg_n is 0, pin 7 has pad_oe 0 and pad_pu 0 in the same cycle, whatever its direction and data bits. pin_in[7] still reads through offset 2 and still drives irq_n[3].
- R9: When chk_en is 0, cfg_n has no effect on any pad signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; registers reset synchronously, pad forcing is combinational |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Synchronized pin levels |
| uart0_map | input | 1 | Map UART channel 0 onto pins 0/1 |
| uart1_map | input | 1 | Map UART channel 1 onto pins 2/3 |
| int_en | input | 4 | Interrupt enables for pins 4..7 |
| chk_en | input | 1 | Enable the check function on pin 7 |
| cfg_n | input | 1 | Configuration-download strobe, active low |
| uart0_txd | input | 1 | UART channel 0 transmit data |
| uart1_txd | input | 1 | UART channel 1 transmit data |
| uart0_rx_en | input | 1 | UART channel 0 receiver enabled |
| uart1_rx_en | input | 1 | UART channel 1 receiver enabled |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up enable |
| uart0_rxd | output | 1 | Receive data to UART channel 0 |
| uart1_rxd | output | 1 | Receive data to UART channel 1 |
| irq_n | output | 4 | Active-low external interrupt requests |

## Verification
A register write that makes pin 7 an output can land in the same cycle that the download strobe falls with the check function enabled. The bench provokes this by asserting the write and cfg_n low on the same edge. It then judges that pin 7 stays floating while offset 1 reads back the new direction, and that the pin drives as soon as cfg_n rises. A second collision holds the direction bit of a receive pin at 1 while its receiver is enabled. The bench checks that the pin stays an input and that its pull-up follows the data bit as that bit is toggled.

// File: rtl/gpio_pkg.sv
// gpio_pkg: shared register offsets, alternate-function pin positions and
// the per-pin pad control type for the GPIO port.
// Assumes an eight-pin port and a two-bit register offset.
package gpio_pkg;
    localparam int PORT_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int N_INT   = 4;
    localparam int INT_LSB = 4;
    localparam int CHK_PIN = 7;
    localparam int U0_TX   = 0;
    localparam int U0_RX   = 1;
    localparam int U1_TX   = 2;
    localparam int U1_RX   = 3;

    localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_PIN  = 2'd2;

    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
    } pad_ctl_t;
endpackage

// File: rtl/gpio_regs.sv
// gpio_regs: data and direction registers with a combinational read mux.
// Assumes a synchronous active-low reset. Writes to the pin-level offset
// and to offset 3 are dropped.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  pin_lvl,
    output logic [W-1:0]  bus_rdata,
    output logic [W-1:0]  data_q,
    output logic [W-1:0]  dir_q
);
    // Register update: pull-ups on and all inputs after reset, else bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '1;
            dir_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_DATA) data_q <= bus_wdata;
            if (bus_addr == OFS_DIR)  dir_q  <= bus_wdata;
        end
    end

    // Read mux: register contents, pin levels, zero for unused offsets.
    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = data_q;
            OFS_DIR:  bus_rdata = dir_q;
            OFS_PIN:  bus_rdata = pin_lvl;
            default:  bus_rdata = '0;
        endcase
    end

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR) |=> (dir_q == $past(bus_wdata))); // R4
    AST_PINREG_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_PIN) |=> ($stable(data_q) && $stable(dir_q))); // R4
endmodule

// File: rtl/gpio_pin_ctl.sv
// gpio_pin_ctl: pad control for one pin. The override priority is reset,
// then check tri-state, then transmit ownership, then forced receive input,
// then the register settings.
// Assumes rst_n is applied combinationally so that reset needs no clock.
module gpio_pin_ctl
    import gpio_pkg::*;
(
    input  logic     rst_n,
    input  logic     dir_bit,
    input  logic     data_bit,
    input  logic     tx_own,
    input  logic     tx_val,
    input  logic     rx_force,
    input  logic     hiz_force,
    output pad_ctl_t ctl
);
    // Priority selection of this pin's pad controls.
    always_comb begin
        if (!rst_n)         ctl = '{oe: 1'b0, out: 1'b0,   pu: 1'b1};
        else if (hiz_force) ctl = '{oe: 1'b0, out: 1'b0,   pu: 1'b0};
        else if (tx_own)    ctl = '{oe: 1'b1, out: tx_val, pu: 1'b0};
        else if (rx_force)  ctl = '{oe: 1'b0, out: 1'b0,   pu: data_bit};
        else if (dir_bit)   ctl = '{oe: 1'b1, out: data_bit, pu: 1'b0};
        else                ctl = '{oe: 1'b0, out: 1'b0,   pu: data_bit};
    end
endmodule

// File: rtl/gpio_irq.sv
// gpio_irq: active-low level interrupt requests from the upper pins.
// Assumes the pin levels are already synchronized. Nothing is latched.
module gpio_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] en,
    output logic [N-1:0] irq_n
);
    for (genvar k = 0; k < N; k++) begin : g_req
        // Request while the enabled pin is low.
        assign irq_n[k] = ~(en[k] & ~lvl[k]);

        AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            (en[k] && !lvl[k]) |-> !irq_n[k]); // R7
        AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            lvl[k] |-> irq_n[k]); // R7
    end
endmodule

// File: rtl/gpio_alt_port.sv
// gpio_alt_port: eight-pin GPIO port. It holds direction and data
// registers and overrides pins per bit for two UART channels, four level
// interrupts and the check-pin tri-state on pin 7.
// Assumes pin_in is already synchronized to clk. Registers reset
// synchronously; pad forcing during reset is combinational.
module gpio_alt_port
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    input  logic              uart0_map,
    input  logic              uart1_map,
    input  logic [N_INT-1:0]  int_en,
    input  logic              chk_en,
    input  logic              cfg_n,
    input  logic              uart0_txd,
    input  logic              uart1_txd,
    input  logic              uart0_rx_en,
    input  logic              uart1_rx_en,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pu,
    output logic              uart0_rxd,
    output logic              uart1_rxd,
    output logic [N_INT-1:0]  irq_n
);
    logic [PORT_W-1:0] data_q, dir_q;
    logic [PORT_W-1:0] tx_own, tx_val, rx_force, hiz_force;

    gpio_regs #(.W(PORT_W), .AW(ADDR_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pin_lvl(pin_in), .bus_rdata(bus_rdata),
        .data_q(data_q), .dir_q(dir_q)
    );

    // Per-pin override vectors from the alternate-function enables.
    always_comb begin
        tx_own    = '0;
        tx_val    = '0;
        rx_force  = '0;
        hiz_force = '0;
        tx_own[U0_TX]      = uart0_map;
        tx_val[U0_TX]      = uart0_txd;
        tx_own[U1_TX]      = uart1_map;
        tx_val[U1_TX]      = uart1_txd;
        rx_force[U0_RX]    = uart0_map & uart0_rx_en;
        rx_force[U1_RX]    = uart1_map & uart1_rx_en;
        hiz_force[CHK_PIN] = chk_en & ~cfg_n;
    end

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        pad_ctl_t ctl;
        gpio_pin_ctl i_pin (
            .rst_n(rst_n), .dir_bit(dir_q[i]), .data_bit(data_q[i]),
            .tx_own(tx_own[i]), .tx_val(tx_val[i]), .rx_force(rx_force[i]),
            .hiz_force(hiz_force[i]), .ctl(ctl)
        );
        assign pad_oe[i]  = ctl.oe;
        assign pad_out[i] = ctl.out;
        assign pad_pu[i]  = ctl.pu;
    end

    // Receive data: pin level while mapped, idle-high otherwise.
    assign uart0_rxd = uart0_map ? pin_in[U0_RX] : 1'b1;
    assign uart1_rxd = uart1_map ? pin_in[U1_RX] : 1'b1;

    gpio_irq #(.N(N_INT)) i_irq (
        .clk(clk), .rst_n(rst_n), .lvl(pin_in[INT_LSB +: N_INT]),
        .en(int_en), .irq_n(irq_n)
    );

    AST_RESET_PULLUP: assert property (@(posedge clk)
        !rst_n |-> (pad_oe == '0 && pad_pu == '1)); // R3
    AST_OE_PU_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0); // R2
    AST_TX0_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        uart0_map |-> (pad_oe[U0_TX] && pad_out[U0_TX] == uart0_txd)); // R5
    AST_RX0_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (uart0_map && uart0_rx_en) |-> (!pad_oe[U0_RX] && pad_pu[U0_RX] == data_q[U0_RX])); // R6
    AST_RX1_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (uart1_map && uart1_rx_en) |-> (!pad_oe[U1_RX] && pad_pu[U1_RX] == data_q[U1_RX])); // R6
    AST_CHK_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !cfg_n) |-> (!pad_oe[CHK_PIN] && !pad_pu[CHK_PIN])); // R8
    AST_DIR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q[5] && !(chk_en && !cfg_n)) |-> (pad_oe[5] && pad_out[5] == data_q[5])); // R1
endmodule

// File: tb/test_gpio_alt_port.sv
`timescale 1ns/1ps
module test_gpio_alt_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in;
    logic       uart0_map = 0, uart1_map = 0;
    logic [3:0] int_en = 4'h0;
    logic       chk_en = 0, cfg_n = 1;
    logic       uart0_txd = 0, uart1_txd = 0;
    logic       uart0_rx_en = 0, uart1_rx_en = 0;
    logic [7:0] pad_oe, pad_out, pad_pu;
    logic       uart0_rxd, uart1_rxd;
    logic [3:0] irq_n;
    logic [7:0] ext_en = 8'h00, ext_val = 8'h00;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // Pad model: the driver wins, then an external source, then the pull-up, else 0.
    always_comb begin
        for (int i = 0; i < 8; i++)
            pin_in[i] = pad_oe[i] ? pad_out[i] : (ext_en[i] ? ext_val[i] : pad_pu[i]);
    end

    gpio_alt_port i_gpio_alt_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .uart0_map(uart0_map), .uart1_map(uart1_map), .int_en(int_en),
        .chk_en(chk_en), .cfg_n(cfg_n), .uart0_txd(uart0_txd),
        .uart1_txd(uart1_txd), .uart0_rx_en(uart0_rx_en),
        .uart1_rx_en(uart1_rx_en), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu), .uart0_rxd(uart0_rxd), .uart1_rxd(uart1_rxd),
        .irq_n(irq_n)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        #0.5;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R3", "oe in reset", pad_oe, 8'h00);
        chk("R3", "pu in reset", pad_pu, 8'hFF);
        @(negedge clk); rst_n = 1'b1; #0.5;
        rd(2'd0, v); chk("R3", "data after reset", v, 8'hFF);
        rd(2'd1, v); chk("R3", "dir after reset", v, 8'h00);
        chk("R2", "pu after reset", pad_pu, 8'hFF);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(2'd0, 8'h3C); wr(2'd1, 8'h0F);
        rd(2'd0, v); chk("R4", "data readback", v, 8'h3C);
        rd(2'd1, v); chk("R4", "dir readback", v, 8'h0F);
        wr(2'd2, 8'h55);
        rd(2'd0, v); chk("R4", "data kept after pin write", v, 8'h3C);
        rd(2'd1, v); chk("R4", "dir kept after pin write", v, 8'h0F);
        rd(2'd2, v); chk("R4", "pin readback", v, 8'h3C);
        rd(2'd3, v); chk("R4", "offset 3", v, 8'h00);
    endtask

    task automatic t_dir();
        // dir=0F, data=3C: low nibble drives C, upper pull-ups follow 3.
        chk("R1", "oe", pad_oe, 8'h0F);
        chk("R1", "out", pad_out, 8'h0C);
        chk("R2", "pu", pad_pu, 8'h30);
        wr(2'd1, 8'hF0); wr(2'd0, 8'hA5);
        chk("R1", "oe 2", pad_oe, 8'hF0);
        chk("R1", "out 2", pad_out, 8'hA0);
        chk("R2", "pu 2", pad_pu, 8'h05);
    endtask

    task automatic t_uart_tx();
        wr(2'd1, 8'h00); wr(2'd0, 8'h00);
        uart0_map = 1; uart1_map = 1; uart0_txd = 1; uart1_txd = 0; #0.5;
        chk("R5", "tx oe", pad_oe & 8'h05, 8'h05);
        chk("R5", "tx out", pad_out & 8'h05, 8'h01);
        uart0_txd = 0; uart1_txd = 1; #0.5;
        chk("R5", "tx out toggled", pad_out & 8'h05, 8'h04);
        uart0_map = 0; uart1_map = 0; #0.5;
        chk("R5", "tx released", pad_oe, 8'h00);
    endtask

    task automatic t_uart_rx();
        wr(2'd1, 8'h0A); wr(2'd0, 8'h02);
        chk("R6", "rxd idle unmapped", {6'd0, uart1_rxd, uart0_rxd}, 8'h03);
        uart0_map = 1; uart1_map = 1; uart0_rx_en = 1; uart1_rx_en = 1; #0.5;
        chk("R6", "rx pins input", pad_oe & 8'h0A, 8'h00);
        chk("R6", "rx pull-ups", pad_pu & 8'h0A, 8'h02);
        wr(2'd0, 8'h08);
        chk("R6", "rx pull-ups toggled", pad_pu & 8'h0A, 8'h08);
        ext_en = 8'h0A; ext_val = 8'h02; #0.5;
        chk("R6", "rxd follows pins", {6'd0, uart1_rxd, uart0_rxd}, 8'h01);
        uart0_rx_en = 0; uart1_rx_en = 0; #0.5;
        chk("R6", "rx disabled dir rules", pad_oe & 8'h0A, 8'h0A);
        uart0_map = 0; uart1_map = 0; ext_en = 8'h00;
    endtask

    task automatic t_irq();
        wr(2'd1, 8'h00); wr(2'd0, 8'h00);
        ext_en = 8'hF0; ext_val = 8'h50; int_en = 4'hF; #0.5;
        chk("R7", "irq levels", {4'd0, irq_n}, 8'h05);
        int_en = 4'h3; #0.5;
        chk("R7", "irq masked", {4'd0, irq_n}, 8'h0D);
        ext_val = 8'hF0; #0.5;
        chk("R7", "irq clears", {4'd0, irq_n}, 8'h0F);
        int_en = 4'h0; ext_en = 8'h00;
    endtask

    task automatic t_check();
        logic [7:0] v;
        wr(2'd1, 8'h80); wr(2'd0, 8'h80);
        cfg_n = 0; #0.5;
        chk("R9", "no effect when disabled", {pad_oe[7], pad_out[7], 6'd0}, 8'hC0);
        // Collision: a direction write lands in the same edge as the strobe falling.
        wr(2'd1, 8'h00); cfg_n = 1;
        @(negedge clk);
        bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'h80; chk_en = 1; cfg_n = 0;
        #0.5;
        chk("R8", "float same cycle", {pad_oe[7], pad_pu[7], 6'd0}, 8'h00);
        @(negedge clk); bus_wr = 0; #0.5;
        rd(2'd1, v); chk("R8", "dir written during float", v, 8'h80);
        chk("R8", "still floating", {pad_oe[7], pad_pu[7], 6'd0}, 8'h00);
        ext_en = 8'h80; ext_val = 8'h00; int_en = 4'h8; #0.5;
        rd(2'd2, v); chk("R8", "pin7 read low", v & 8'h80, 8'h00);
        chk("R8", "int3 low", {4'd0, irq_n}, 8'h07);
        ext_val = 8'h80; #0.5;
        rd(2'd2, v); chk("R8", "pin7 read high", v & 8'h80, 8'h80);
        ext_en = 8'h00; int_en = 4'h0;
        cfg_n = 1; #0.5;
        chk("R8", "drives after strobe", {pad_oe[7], pad_out[7], 6'd0}, 8'hC0);
        chk_en = 0;
    endtask

    task automatic t_async_reset();
        wr(2'd1, 8'hFF); wr(2'd0, 8'h00);
        rst_n = 0; #0.5;
        chk("R3", "oe no edge", pad_oe, 8'h00);
        chk("R3", "pu no edge", pad_pu, 8'hFF);
        @(negedge clk); @(negedge clk); rst_n = 1; #0.5;
        chk("R3", "dir cleared", pad_oe, 8'h00);
    endtask

    initial begin
        @(negedge clk); #0.5;
        t_reset();
        t_regs();
        t_dir();
        t_uart_tx();
        t_uart_rx();
        t_irq();
        t_check();
        t_async_reset();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule